// File: doc/BRIEF.md
# Qualified Write Register Bank

This block is the register bank a communication controller exposes to its host bus. It stores control, command, timing and per-message-buffer fields. Every field has its own write qualifier, built as a logical OR of conditions. The conditions come from the stored module-enable bit, the protocol state, and the enable and lock status of the related message buffer. A write that fails its qualifier is dropped with no response of any kind, and the stored value stays as it was. The host writes bytes, halfwords or words through four byte-lane strobes. The command register only accepts writes of at least 16 bits.

Some fields also return to their reset value on two events besides reset. The first is an accepted protocol RUN command. The second is a granted message-buffer disable. The protocol state, the buffer status bits and the disable-grant pulses come from neighbouring logic as sideband inputs. Reads are registered and have no side effects.

Map (word index): 0 control (bit 0 module enable, any time; bits 15:8 setup byte, disabled mode only). 1 command (bits 3:0 protocol command, normal mode only; bits 23:16 run counter, any time, cleared by RUN; wide access required). 2 timing (bits 7:0, protocol in config OR disabled mode). 4+n buffer n (bit 0 disable trigger, write-only, normal mode; bits 15:8 frame id, buffer enable status 0; bits 23:16 pointer, buffer lock status 1; bits 31:24 flags, any time, cleared by granted disable).

Top module: `cc_wr_gate_regs`

## Requirements
- R1: A write whose qualifier is false leaves the field unchanged, and no output signals it (timing byte written in normal mode outside config keeps its value).
- R2: A field with several conditions accepts a write when any one holds: the timing byte is writable with protocol state equal to CFG_STATE (default 1) even in normal mode, and in disabled mode in any protocol state.
- R3: The setup byte accepts writes only while module enable is 0. The protocol command accepts writes only while module enable is 1.
- R4: The frame id of buffer n accepts writes only while mb_en_sts[n] is 0. Its pointer accepts writes only while mb_lock_sts[n] is 1.
- R5: Only byte lanes whose strobe be[k] is 1 (lane k is wdata[8k+7:8k]) are updated. 8-, 16- and 32-bit writes are all accepted on ordinary registers.
- R6: A write to the command register with fewer than two strobes set is ignored in full. A 16-bit or 32-bit write is accepted.
- R7: An accepted command write of 4'b0101 to bits 3:0 sets the run counter back to its reset value (0). Other command codes leave it alone.
- R8: Writing 1 to a buffer's trigger bit in normal mode while its mb_en_sts is 1 makes a disable pending. A later mb_dis_grant pulse then sets that buffer's flags back to 0. A grant with no pending disable changes nothing.
- R9: When an event reset and an accepted write target the same field in the same cycle, the field takes its reset value.
- R10: rd_en samples the addressed register into rdata at the next clock edge. rdata holds while rd_en is low, reads change no state, and the trigger bit reads 0.
- R11: After reset every field and rdata are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| addr | input | ADDR_W | Word index |
| be | input | 4 | Byte-lane strobes |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data |
| proto_state | input | PST_W | Current protocol state |
| mb_en_sts | input | NUM_MB | Per-buffer enable status |
| mb_lock_sts | input | NUM_MB | Per-buffer lock status |
| mb_dis_grant | input | NUM_MB | Per-buffer disable-grant pulse |

## Verification
A vector table walks the registers through disabled and normal mode. It uses byte, halfword, upper-halfword and word strobe patterns, so lane masking can be told apart from qualifier rejection and from the wide-access rule. Directed sequences then vary one sideband condition at a time: protocol state, lock and buffer enable status. This shows that each OR term alone opens its field. The event resets are tried with a non-RUN code, with a grant that has no pending disable, and with a trigger issued while the buffer was already disabled. A grant that coincides with a flag write shows which of the two wins.

// File: rtl/cc_wr_gate_regs.sv
module cc_wr_gate_regs #(
  parameter int ADDR_W = 4,
  parameter int NUM_MB = 2,
  parameter int PST_W = 3,
  parameter int MB_BASE = 4,
  parameter logic [PST_W-1:0] CFG_STATE = 3'd1,
  parameter logic [3:0] RUN_CODE = 4'b0101,
  parameter logic [7:0] RUNCNT_RST = 8'h00,
  parameter logic [7:0] FLG_RST = 8'h00
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        be,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [PST_W-1:0]  proto_state,
  input  logic [NUM_MB-1:0] mb_en_sts,
  input  logic [NUM_MB-1:0] mb_lock_sts,
  input  logic [NUM_MB-1:0] mb_dis_grant
);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PCMD = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_TIMG = ADDR_W'(2);

  logic       mod_en;
  logic [7:0] dm_cfg, tmg, run_cnt;
  logic [3:0] cmd;
  logic [NUM_MB-1:0][7:0] fid, ptr, flg;
  logic [NUM_MB-1:0] dis_pend;
  logic [31:0] rd_mux;

  wire in_cfg   = (proto_state == CFG_STATE);
  wire wide_ok  = ($countones(be) > 1);
  wire hit_ctrl = wr_en && (addr == A_CTRL);
  wire hit_pcmd = wr_en && (addr == A_PCMD) && wide_ok;
  wire hit_timg = wr_en && (addr == A_TIMG);
  wire cmd_acc  = hit_pcmd && be[0] && mod_en;
  wire run_evt  = cmd_acc && (wdata[3:0] == RUN_CODE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_en  <= 1'b0;
      dm_cfg  <= '0;
      tmg     <= '0;
      cmd     <= '0;
      run_cnt <= RUNCNT_RST;
    end else begin
      if (hit_ctrl && be[0]) mod_en <= wdata[0];
      if (hit_ctrl && be[1] && !mod_en) dm_cfg <= wdata[15:8];
      if (hit_timg && be[0] && (in_cfg || !mod_en)) tmg <= wdata[7:0];
      if (cmd_acc) cmd <= wdata[3:0];
      if (run_evt) run_cnt <= RUNCNT_RST;
      else if (hit_pcmd && be[2]) run_cnt <= wdata[23:16];
    end
  end

  for (genvar g = 0; g < NUM_MB; g++) begin : g_mb
    localparam logic [ADDR_W-1:0] MY_A = ADDR_W'(MB_BASE + g);
    wire hit       = wr_en && (addr == MY_A);
    wire trig_acc  = hit && be[0] && wdata[0] && mod_en && mb_en_sts[g];
    wire grant_evt = dis_pend[g] && mb_dis_grant[g];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        dis_pend[g] <= 1'b0;
        fid[g]      <= '0;
        ptr[g]      <= '0;
        flg[g]      <= FLG_RST;
      end else begin
        if (grant_evt) dis_pend[g] <= 1'b0;
        else if (trig_acc) dis_pend[g] <= 1'b1;
        if (hit && be[1] && !mb_en_sts[g]) fid[g] <= wdata[15:8];
        if (hit && be[2] && mb_lock_sts[g]) ptr[g] <= wdata[23:16];
        if (grant_evt) flg[g] <= FLG_RST;
        else if (hit && be[3]) flg[g] <= wdata[31:24];
      end
    end

    // R8
    grant_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      dis_pend[g] && mb_dis_grant[g] |=> (flg[g] == FLG_RST) && !dis_pend[g]);
    // R8
    flg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !dis_pend[g] && !(wr_en && addr == MY_A && be[3]) |=> $stable(flg[g]));
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      A_CTRL: rd_mux = {16'h0, dm_cfg, 7'h0, mod_en};
      A_PCMD: rd_mux = {8'h0, run_cnt, 12'h0, cmd};
      A_TIMG: rd_mux = {24'h0, tmg};
      default: ;
    endcase
    for (int i = 0; i < NUM_MB; i++)
      if (addr == ADDR_W'(MB_BASE + i)) rd_mux = {flg[i], ptr[i], fid[i], 8'h0};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else if (rd_en) rdata <= rd_mux;
  end

  // R6
  narrow_pcmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_PCMD && $countones(be) < 2 |=> $stable(cmd) && $stable(run_cnt));
  // R1
  timg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && addr == A_TIMG && !in_cfg && mod_en |=> $stable(tmg));
  // R7
  run_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_evt |=> run_cnt == RUNCNT_RST);
  // R10
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata));
endmodule

// File: tb/cc_wr_gate_regs_bench.sv
`timescale 1ns/1ps
module cc_wr_gate_regs_bench;
  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0, be = 0;
  logic [31:0] wdata = 0, rdata;
  logic [2:0] proto_state = 0;
  logic [1:0] mb_en_sts = 0, mb_lock_sts = 0, mb_dis_grant = 0;
  int nchk = 0, nfail = 0;
  logic [31:0] got;

  always #4 clk = ~clk;

  cc_wr_gate_regs u_cc_wr_gate_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .be(be),
    .wdata(wdata), .rdata(rdata), .proto_state(proto_state), .mb_en_sts(mb_en_sts),
    .mb_lock_sts(mb_lock_sts), .mb_dis_grant(mb_dis_grant));

  // {addr, be, wdata, expected readback, requirement number}
  localparam logic [79:0] VEC [14] = '{
    {4'h0, 4'hF, 32'h0000AB00, 32'h0000AB00, 8'd3},  // R3 setup byte in disabled mode
    {4'h2, 4'h1, 32'h0000005A, 32'h0000005A, 8'd2},  // R2 disabled term
    {4'h1, 4'hF, 32'h00110003, 32'h00110000, 8'd3},  // R3 command refused
    {4'h0, 4'h1, 32'h00000001, 32'h0000AB01, 8'd5},  // R5 enable module
    {4'h0, 4'h2, 32'h0000CD00, 32'h0000AB01, 8'd3},  // R3 setup locked in normal
    {4'h2, 4'h1, 32'h00000077, 32'h0000005A, 8'd1},  // R1 dropped
    {4'h1, 4'h1, 32'h00000003, 32'h00110000, 8'd6},  // R6 narrow
    {4'h1, 4'h3, 32'h00000003, 32'h00110003, 8'd6},  // R6 halfword
    {4'h1, 4'hC, 32'h00220000, 32'h00220003, 8'd5},  // R5 upper half
    {4'h1, 4'hF, 32'h00330005, 32'h00000005, 8'd9},  // R9 RUN beats write
    {4'h4, 4'h2, 32'h00004200, 32'h00004200, 8'd4},  // R4 frame id
    {4'h4, 4'h4, 32'h00990000, 32'h00004200, 8'd4},  // R4 pointer unlocked
    {4'h4, 4'h8, 32'hC3000000, 32'hC3004200, 8'd5},  // R5 flags lane
    {4'h5, 4'hF, 32'h12345678, 32'h12005600, 8'd5}   // R5 word
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [3:0] b, input logic [31:0] d,
                    input logic [1:0] gr = 2'b00);
    @(negedge clk);
    wr_en = 1; addr = a; be = b; wdata = d; mb_dis_grant = gr;
    @(negedge clk);
    wr_en = 0; be = 0; mb_dis_grant = 0;
  endtask

  task automatic grant(input logic [1:0] gr);
    @(negedge clk); mb_dis_grant = gr;
    @(negedge clk); mb_dis_grant = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    @(negedge clk); rd_en = 1; addr = a;
    @(negedge clk); rd_en = 0; got = rdata;
  endtask

  task automatic summary;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R11 rdata", rdata, 32'h0);
    rst_n = 1;
    rd(4'h0); chk("R11 ctrl", got, 0);
    rd(4'h1); chk("R11 cmd", got, 0);
    rd(4'h2); chk("R11 timing", got, 0);
    rd(4'h4); chk("R11 mb0", got, 0);
    rd(4'h5); chk("R11 mb1", got, 0);

    foreach (VEC[i]) begin
      wr(VEC[i][79:76], VEC[i][75:72], VEC[i][71:40]);
      rd(VEC[i][79:76]);
      chk($sformatf("R%0d vec%0d", VEC[i][7:0], i), got, VEC[i][39:8]);
    end

    proto_state = 3'd1;
    wr(4'h2, 4'h1, 32'h99);
    proto_state = 3'd0;
    rd(4'h2); chk("R2 config term", got, 32'h99);

    wr(4'h1, 4'hF, 32'h00440006);
    rd(4'h1); chk("R7 non-RUN code", got, 32'h00440006);
    wr(4'h1, 4'h3, 32'h00000005);
    rd(4'h1); chk("R7 RUN clears", got, 32'h00000005);

    mb_lock_sts[0] = 1;
    wr(4'h4, 4'h4, 32'h00990000);
    rd(4'h4); chk("R4 locked pointer", got, 32'hC3994200);
    mb_en_sts[0] = 1;
    wr(4'h4, 4'h2, 32'h00001100);
    rd(4'h4); chk("R4 enabled frame id", got, 32'hC3994200);

    grant(2'b01);
    rd(4'h4); chk("R8 grant no pending", got, 32'hC3994200);
    wr(4'h4, 4'h1, 32'h1);
    rd(4'h4); chk("R10 trigger reads 0", got, 32'hC3994200);
    grant(2'b01);
    rd(4'h4); chk("R8 grant clears", got, 32'h00994200);

    wr(4'h5, 4'h1, 32'h1);
    grant(2'b10);
    rd(4'h5); chk("R8 trigger while disabled", got, 32'h12005600);

    mb_en_sts[1] = 1;
    wr(4'h5, 4'h1, 32'h1);
    wr(4'h5, 4'h8, 32'hEE000000, 2'b10);
    rd(4'h5); chk("R9 grant beats write", got, 32'h00005600);

    rd(4'h2); chk("R10 read", got, 32'h99);
    wr(4'h2, 4'h1, 32'h11);
    @(negedge clk); chk("R10 hold", rdata, 32'h99);
    rd(4'h2); chk("R10 no side effect", got, 32'h99);

    wr(4'h0, 4'h1, 32'h0);
    wr(4'h1, 4'h3, 32'h00000007);
    rd(4'h1); chk("R3 command in disabled", got, 32'h00000005);
    wr(4'h0, 4'h2, 32'h00007700);
    rd(4'h0); chk("R3 setup in disabled", got, 32'h00007700);
    summary();
  end
endmodule